// File: doc/BRIEF.md
# Downstream Port Power and Overcurrent Controller

This block looks after the supply switches of a hub's downstream ports. Decoded host requests turn a port's supply switch on or off, and clear that port's latched overcurrent change flag. A switch can only be turned on once the hub reports that it is configured. Each port has an overcurrent comparator result. That result is synchronized and then filtered, so that it must stay high for a programmable number of cycles before the block acts on it.

A qualified overcurrent does three things on one clock edge: it releases the port's switch, it raises the live overcurrent status, and it sets a sticky change flag. The host must clear the change flag. Power comes back only when the host sends a fresh power request.

Each switch output is active low and open drain. It is modelled as a sink-enable bit: 1 pulls the line low, which switches the port on, and 0 releases the line. A per-port connect indicator shows that a port is enabled and powered.

Top module: `port_pwr_ctrl`

## Requirements
- R1: After reset every sink enable, connect indicator, overcurrent status and change flag is 0.
- R2: A request with req_set_i=1 and feature code 0 (power) addressed to port p sets pwr_sink_o[p] on the next edge, provided hub_cfg_i is 1 and no qualified overcurrent is present on p. Other ports are not changed.
- R3: While hub_cfg_i is 0, power requests are ignored, and every sink enable is 0 one edge after hub_cfg_i is seen low.
- R4: A request with req_set_i=0 and feature code 0 addressed to port p clears pwr_sink_o[p] on the next edge.
- R5: oc_raw_i passes through two flops. An overcurrent qualifies once the synchronized level has been high for oc_hold_i+1 consecutive cycles. If oc_raw_i goes high in a cycle and stays high, the outputs react at edge oc_hold_i+3. A high pulse seen by only oc_hold_i edges has no effect.
- R6: On the edge after qualification, the port's sink enable drops, oc_stat_o goes to 1, and oc_chg_o goes to 1 if the status was 0. All of these happen on that same edge.
- R7: oc_stat_o follows the qualified level. It returns to 0 on the third edge after oc_raw_i falls.
- R8: oc_chg_o stays set until a request with req_set_i=0 and feature code 1 (overcurrent change) addresses that port. Clearing it leaves oc_stat_o unchanged. The same code with req_set_i=1 has no effect.
- R9: Power is never restored by itself after an overcurrent. A power request made while the overcurrent is still qualified is ignored. A new power request after the overcurrent clears turns the port back on.
- R10: conn_o[p] on each edge takes the value of port_en_i[p] AND the sink enable that p had before that edge.
- R11: Feature codes 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hub_cfg_i | input | 1 | Hub has been configured by the host |
| req_valid_i | input | 1 | A decoded port request is present this cycle |
| req_set_i | input | 1 | 1 = set feature, 0 = clear feature |
| req_feat_i | input | 2 | Feature code: 0 power, 1 overcurrent change, 2 and 3 unused |
| req_port_i | input | 2 | Target port index |
| port_en_i | input | 4 | Per-port enabled flag |
| oc_raw_i | input | 4 | Per-port overcurrent comparator result |
| oc_hold_i | input | 4 | Extra synchronized cycles before an overcurrent qualifies |
| pwr_sink_o | output | 4 | 1 pulls the active-low switch line low (port on), 0 releases it |
| conn_o | output | 4 | Connect indicator per port |
| oc_stat_o | output | 4 | Live qualified overcurrent status |
| oc_chg_o | output | 4 | Sticky overcurrent change flag |

## Verification
The bench sweeps every hold setting from 0 to 3 on every port. For each setting it checks that a pulse one cycle too short is filtered out, and that a held fault cuts power exactly at edge hold+3. A filter that is off by one would cut power a cycle early or a cycle late, or would let the short pulse through.

The bench then tries to turn power back on while the fault is still present, and clears the change flag while the status remains high. A design that restores power, clears the status, or sets the flag again would produce a powered port or a stale flag. Deconfiguring the hub, and requests with the unused feature codes, show whether power follows the configured flag alone.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    FEAT_POWER  = 2'd0,
    FEAT_OC_CHG = 2'd1,
    FEAT_RSVD2  = 2'd2,
    FEAT_RSVD3  = 2'd3
  } feat_e;

  typedef struct packed {
    logic set_pwr;
    logic clr_pwr;
    logic clr_chg;
  } port_cmd_t;
endpackage

// File: rtl/req_decode.sv
module req_decode
  import pwr_pkg::*;
#(
  parameter int N_PORTS = 4,
  localparam int PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                      req_valid_i,
  input  logic                      req_set_i,
  input  logic [1:0]                req_feat_i,
  input  logic [PORT_W-1:0]         req_port_i,
  output port_cmd_t [N_PORTS-1:0]   cmd_o
);
  feat_e feat;
  assign feat = feat_e'(req_feat_i);

  for (genvar i = 0; i < N_PORTS; i++) begin : g_dec
    logic hit;
    assign hit = req_valid_i && (req_port_i == PORT_W'(i));
    assign cmd_o[i].set_pwr = hit &&  req_set_i && (feat == FEAT_POWER);
    assign cmd_o[i].clr_pwr = hit && !req_set_i && (feat == FEAT_POWER);
    assign cmd_o[i].clr_chg = hit && !req_set_i && (feat == FEAT_OC_CHG);
  end
endmodule

// File: rtl/oc_filter.sv
module oc_filter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             oc_raw_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic             qual_o
);
  logic             meta_q, sync_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      meta_q <= oc_raw_i;
      sync_q <= meta_q;
      if (!sync_q)           cnt_q <= '0;
      else if (cnt_q < hold_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign qual_o = sync_q && (cnt_q >= hold_i);

  AST_QUAL_AFTER_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qual_o && hold_i != '0 && $stable(hold_i)) |-> $past(sync_q)); // R5
endmodule

// File: rtl/port_slice.sv
module port_slice
  import pwr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hub_cfg_i,
  input  port_cmd_t cmd_i,
  input  logic      oc_qual_i,
  input  logic      port_en_i,
  output logic      pwr_o,
  output logic      conn_o,
  output logic      stat_o,
  output logic      chg_o
);
  logic pwr_q, conn_q, stat_q, chg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q  <= 1'b0;
      conn_q <= 1'b0;
      stat_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      // fault and deconfig win over any request
      if (!hub_cfg_i || oc_qual_i || cmd_i.clr_pwr) pwr_q <= 1'b0;
      else if (cmd_i.set_pwr)                     pwr_q <= 1'b1;
      stat_q <= oc_qual_i;
      if (oc_qual_i && !stat_q) chg_q <= 1'b1;
      else if (cmd_i.clr_chg)   chg_q <= 1'b0;
      conn_q <= port_en_i && pwr_q;
    end
  end

  assign pwr_o  = pwr_q;
  assign conn_o = conn_q;
  assign stat_o = stat_q;
  assign chg_o  = chg_q;

  AST_NO_PWR_UNCFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hub_cfg_i |=> !pwr_q); // R3
  AST_OC_CUTS_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_qual_i |=> (!pwr_q && stat_q)); // R6
  AST_CHG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_q && !cmd_i.clr_chg) |=> chg_q); // R8
  AST_PWR_BY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_q && !cmd_i.set_pwr) |=> !pwr_q); // R9
  AST_CONN_NEEDS_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_q |=> !conn_q); // R10
endmodule

// File: rtl/port_pwr_ctrl.sv
module port_pwr_ctrl
  import pwr_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int CNT_W   = 4,
  localparam int PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hub_cfg_i,
  input  logic               req_valid_i,
  input  logic               req_set_i,
  input  logic [1:0]         req_feat_i,
  input  logic [PORT_W-1:0]  req_port_i,
  input  logic [N_PORTS-1:0] port_en_i,
  input  logic [N_PORTS-1:0] oc_raw_i,
  input  logic [CNT_W-1:0]   oc_hold_i,
  output logic [N_PORTS-1:0] pwr_sink_o,
  output logic [N_PORTS-1:0] conn_o,
  output logic [N_PORTS-1:0] oc_stat_o,
  output logic [N_PORTS-1:0] oc_chg_o
);
  port_cmd_t [N_PORTS-1:0] cmd;
  logic      [N_PORTS-1:0] qual;
  logic      [N_PORTS-1:0] set_vec;

  req_decode #(.N_PORTS(N_PORTS)) u_dec (
    .req_valid_i (req_valid_i),
    .req_set_i   (req_set_i),
    .req_feat_i  (req_feat_i),
    .req_port_i  (req_port_i),
    .cmd_o       (cmd)
  );

  for (genvar i = 0; i < N_PORTS; i++) begin : g_port
    assign set_vec[i] = cmd[i].set_pwr;

    oc_filter #(.CNT_W(CNT_W)) u_flt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .oc_raw_i (oc_raw_i[i]),
      .hold_i   (oc_hold_i),
      .qual_o   (qual[i])
    );

    port_slice u_slice (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hub_cfg_i (hub_cfg_i),
      .cmd_i     (cmd[i]),
      .oc_qual_i (qual[i]),
      .port_en_i (port_en_i[i]),
      .pwr_o     (pwr_sink_o[i]),
      .conn_o    (conn_o[i]),
      .stat_o    (oc_stat_o[i]),
      .chg_o     (oc_chg_o[i])
    );
  end

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(set_vec)); // R2
  AST_RSVD_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_feat_i[1] && hub_cfg_i && !$isunknown(qual) && qual == '0)
      |=> pwr_sink_o == $past(pwr_sink_o)); // R11
endmodule

// File: tb/sim_port_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_port_pwr_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hub_cfg_i = 1'b0;
  logic       req_valid_i = 1'b0;
  logic       req_set_i = 1'b0;
  logic [1:0] req_feat_i = 2'd0;
  logic [1:0] req_port_i = 2'd0;
  logic [3:0] port_en_i = 4'h0;
  logic [3:0] oc_raw_i = 4'h0;
  logic [3:0] oc_hold_i = 4'h0;
  logic [3:0] pwr_sink_o, conn_o, oc_stat_o, oc_chg_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [3:0] exp_pwr = 4'h0;

  always #2.5 clk = ~clk;

  port_pwr_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .hub_cfg_i(hub_cfg_i),
    .req_valid_i(req_valid_i), .req_set_i(req_set_i), .req_feat_i(req_feat_i),
    .req_port_i(req_port_i), .port_en_i(port_en_i), .oc_raw_i(oc_raw_i),
    .oc_hold_i(oc_hold_i), .pwr_sink_o(pwr_sink_o), .conn_o(conn_o),
    .oc_stat_o(oc_stat_o), .oc_chg_o(oc_chg_o)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic req(input logic set, input logic [1:0] feat, input int p);
    req_valid_i = 1'b1; req_set_i = set; req_feat_i = feat; req_port_i = p[1:0];
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  initial begin
    step(2);
    rst_ni = 1'b1;
    step(1);
    chk("R1 sink", pwr_sink_o, 4'h0);
    chk("R1 conn", conn_o, 4'h0);
    chk("R1 stat", oc_stat_o, 4'h0);
    chk("R1 chg", oc_chg_o, 4'h0);

    req(1'b1, 2'd0, 0);
    chk("R3 unconfigured set", pwr_sink_o, 4'h0);

    hub_cfg_i = 1'b1;
    step(1);
    for (int p = 0; p < 4; p++) begin
      req(1'b1, 2'd0, p);
      exp_pwr[p] = 1'b1;
      chk("R2 set power", pwr_sink_o, exp_pwr);
    end

    for (int f = 2; f < 4; f++) begin
      req(1'b0, f[1:0], 0);
      req(1'b1, f[1:0], 1);
      chk("R11 unused code", pwr_sink_o, exp_pwr);
      chk("R11 unused code chg", oc_chg_o, 4'h0);
    end

    req(1'b0, 2'd0, 1);
    exp_pwr[1] = 1'b0;
    chk("R4 clear power", pwr_sink_o, exp_pwr);
    port_en_i = 4'hF;
    step(1);
    chk("R10 conn follows", conn_o, exp_pwr);
    req(1'b1, 2'd0, 1);
    exp_pwr[1] = 1'b1;
    chk("R2 set again", pwr_sink_o, exp_pwr);
    step(1);
    chk("R10 conn powered", conn_o, 4'hF);

    for (int h = 0; h < 4; h++) begin
      for (int p = 0; p < 4; p++) begin
        oc_hold_i = h[3:0];
        if (h > 0) begin
          oc_raw_i[p] = 1'b1;
          step(h);
          oc_raw_i[p] = 1'b0;
          step(5);
          chk("R5 short pulse", pwr_sink_o, exp_pwr);
          chk("R5 short pulse chg", oc_chg_o, 4'h0);
        end
        oc_raw_i[p] = 1'b1;
        step(h + 2);
        chk("R5 before qualify", pwr_sink_o, exp_pwr);
        chk("R5 before qualify stat", oc_stat_o, 4'h0);
        step(1);
        exp_pwr[p] = 1'b0;
        chk("R6 power cut", pwr_sink_o, exp_pwr);
        chk("R6 stat set", oc_stat_o, 4'h1 << p);
        chk("R6 chg set", oc_chg_o, 4'h1 << p);
        req(1'b1, 2'd0, p);
        chk("R9 set during fault", pwr_sink_o, exp_pwr);
        req(1'b0, 2'd1, p);
        chk("R8 clear chg", oc_chg_o, 4'h0);
        chk("R8 stat kept", oc_stat_o, 4'h1 << p);
        oc_raw_i[p] = 1'b0;
        step(2);
        chk("R7 stat holds", oc_stat_o, 4'h1 << p);
        step(1);
        chk("R7 stat falls", oc_stat_o, 4'h0);
        step(2);
        chk("R9 no auto restore", pwr_sink_o, exp_pwr);
        req(1'b1, 2'd0, p);
        exp_pwr[p] = 1'b1;
        chk("R9 restore by request", pwr_sink_o, exp_pwr);
      end
    end

    oc_hold_i = 4'd1;
    oc_raw_i[2] = 1'b1;
    step(4);
    oc_raw_i[2] = 1'b0;
    exp_pwr[2] = 1'b0;
    step(4);
    chk("R8 chg after fault gone", oc_chg_o, 4'h4);
    chk("R7 stat gone", oc_stat_o, 4'h0);
    req(1'b1, 2'd1, 2);
    chk("R8 set code ignored", oc_chg_o, 4'h4);
    req(1'b0, 2'd1, 3);
    chk("R8 other port clear", oc_chg_o, 4'h4);
    req(1'b0, 2'd1, 2);
    chk("R8 cleared", oc_chg_o, 4'h0);
    chk("R6 power stays off", pwr_sink_o, exp_pwr);

    hub_cfg_i = 1'b0;
    step(1);
    chk("R3 deconfig drops", pwr_sink_o, 4'h0);
    step(1);
    chk("R10 conn drops", conn_o, 4'h0);
    req(1'b1, 2'd0, 0);
    chk("R3 set ignored", pwr_sink_o, 4'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule